// File: doc/BRIEF.md
# Conditional Move and Set Unit

This unit chooses, in one combinational step, what gets written to an instruction's destination. It tests one of eight flag conditions against the N, C, Z and V status bits. According to an operation select, it then does one of four things:
- copies a byte-truncated source value into the destination,
- does that copy only when the condition holds,
- writes the condition outcome as the value 0 or 1,
- does nothing.

When a move is carried out, it also produces new zero and negative flags, taken at the width the move used.

The unit sits between operand fetch and writeback in an execution pipeline. It takes the fetched source, the current destination contents, an operand byte-size code and the live flags. It returns the value to write back, a destination write strobe, a flag write strobe and the Z/N values to store. The caller handles fetching operands and writing results. The unit holds no state.

Top module: `cms_unit`

## Requirements
- R1: The 3-bit condition select `condSel` works as follows. Bits [2:1] pick a flag: 00 picks N, 01 picks C, 10 picks Z, 11 picks V. Bit [0] picks the polarity: 0 means the condition holds when that flag is 1, and 1 means it holds when that flag is 0.
- R2: The 2-bit `opSel` encodes 0 as unconditional move, 1 as conditional move, 2 as set, and 3 as idle. Idle leaves `dstOut` equal to `dstVal`, drives `dstWe` and `flagWe` low, and echoes the input Z and N flags on `zOut` and `nOut`.
- R3: A size code above 7 behaves as 7. A move result keeps bytes 0 to code of `srcVal` and clears every higher byte.
- R4: A performed move drives `flagWe` and `dstWe` high. It sets `zOut` when the truncated result is zero and takes `nOut` from result bit (code+1)*8-1.
- R5: A conditional move whose condition fails gives `dstOut` equal to `dstVal`. It drives `dstWe` and `flagWe` low and echoes the input Z and N flags.
- R6: Set drives `dstOut` to 1 when the condition holds and 0 otherwise, with `dstWe` high. The flags are unchanged: `flagWe` is low and Z and N are echoed.
- R7: An unconditional move always performs the truncated move and the flag update, whatever the condition select and the flags are.
- R8: All outputs are combinational functions of the present inputs and are valid in the same cycle the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| flagN | input | 1 | Current negative flag |
| flagC | input | 1 | Current carry flag |
| flagZ | input | 1 | Current zero flag |
| flagV | input | 1 | Current overflow flag |
| condSel | input | 3 | Condition select (flag index and polarity) |
| opSel | input | 2 | Operation select |
| sizeCode | input | 4 | Operand byte-size code, byte count minus one |
| srcVal | input | 64 | Source operand value |
| dstVal | input | 64 | Current destination value |
| dstOut | output | 64 | Value to write to the destination |
| dstWe | output | 1 | Destination write strobe |
| flagWe | output | 1 | Z/N flag write strobe |
| zOut | output | 1 | Zero flag to store |
| nOut | output | 1 | Negative flag to store |

## Verification
No register sits on any path, so every result is due in the same cycle as its stimulus, with zero cycles of latency. The bench drives each vector just after a falling clock edge and samples all five outputs one nanosecond later, well before the next rising edge. The sweep covers every operation, condition, flag combination and size code, including the clamped codes 8 to 15, against four source patterns. The expected values are computed arithmetically from the requirements.

// File: rtl/cms_pkg.sv
package cms_pkg;

  typedef enum logic [1:0] {
    OP_MOVE  = 2'd0,
    OP_CMOVE = 2'd1,
    OP_SET   = 2'd2,
    OP_IDLE  = 2'd3
  } cmsOp_e;

  // Strobes handed from control to datapath
  typedef struct packed {
    logic doMove;   // drive truncated source
    logic doSet;    // drive condition outcome as 0/1
    logic condMet;  // evaluated condition
    logic wrDst;    // destination write strobe
    logic wrFlags;  // Z/N write strobe
  } cmsStrobes_t;

  localparam int FLAG_SEL_W = 2;

endpackage

// File: rtl/cms_ctrl.sv
module cms_ctrl
  import cms_pkg::*;
(
  input  logic       flagN,
  input  logic       flagC,
  input  logic       flagZ,
  input  logic       flagV,
  input  logic [2:0] condSel,
  input  logic [1:0] opSel,
  output cmsStrobes_t strobes
);

  logic [3:0] flagVec;
  logic       pickedFlag;
  logic       condHolds;
  cmsOp_e     opKind;

  // R1: index order N, C, Z, V; bit 0 inverts polarity
  assign flagVec    = {flagV, flagZ, flagC, flagN};
  assign pickedFlag = flagVec[condSel[2:1]];
  assign condHolds  = pickedFlag ^ condSel[0];
  assign opKind     = cmsOp_e'(opSel);

  always_comb begin
    strobes         = '0;
    strobes.condMet = condHolds;
    unique case (opKind)
      OP_MOVE: begin
        strobes.doMove  = 1'b1;
        strobes.wrDst   = 1'b1;
        strobes.wrFlags = 1'b1;
      end
      OP_CMOVE: begin
        strobes.doMove  = condHolds;
        strobes.wrDst   = condHolds;
        strobes.wrFlags = condHolds;
      end
      OP_SET: begin
        strobes.doSet = 1'b1;
        strobes.wrDst = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/cms_datapath.sv
module cms_datapath
  import cms_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SIZE_W = 4
) (
  input  cmsStrobes_t         strobes,
  input  logic [SIZE_W-1:0]   sizeCode,
  input  logic [DATA_W-1:0]   srcVal,
  input  logic [DATA_W-1:0]   dstVal,
  input  logic                flagN,
  input  logic                flagZ,
  output logic [DATA_W-1:0]   dstOut,
  output logic                zOut,
  output logic                nOut
);

  localparam int NBYTES = DATA_W / 8;
  localparam int CODE_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [SIZE_W-1:0] MAX_CODE = SIZE_W'(NBYTES - 1);

  logic [CODE_W-1:0] clampCode;
  logic [NBYTES-1:0] byteKeep;
  logic [NBYTES-1:0] byteMsb;
  logic [DATA_W-1:0] trimmed;
  logic              trimZero;
  logic              trimNeg;

  // R3: codes past the widest operand saturate
  assign clampCode = (sizeCode > MAX_CODE) ? CODE_W'(MAX_CODE) : CODE_W'(sizeCode);

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign byteKeep[b]          = (CODE_W'(b) <= clampCode);
    assign trimmed[b*8 +: 8]    = byteKeep[b] ? srcVal[b*8 +: 8] : 8'h00;
    assign byteMsb[b]           = trimmed[b*8 + 7];
  end

  assign trimZero = (trimmed == '0);
  assign trimNeg  = byteMsb[clampCode];

  always_comb begin
    if (strobes.doMove)
      dstOut = trimmed;
    else if (strobes.doSet)
      dstOut = DATA_W'(strobes.condMet);
    else
      dstOut = dstVal;
  end

  assign zOut = strobes.wrFlags ? trimZero : flagZ;
  assign nOut = strobes.wrFlags ? trimNeg  : flagN;

endmodule

// File: rtl/cms_unit.sv
module cms_unit
  import cms_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SIZE_W = 4
) (
  input  logic              flagN,
  input  logic              flagC,
  input  logic              flagZ,
  input  logic              flagV,
  input  logic [2:0]        condSel,
  input  logic [1:0]        opSel,
  input  logic [SIZE_W-1:0] sizeCode,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [DATA_W-1:0] dstVal,
  output logic [DATA_W-1:0] dstOut,
  output logic              dstWe,
  output logic              flagWe,
  output logic              zOut,
  output logic              nOut
);

  cmsStrobes_t strobes;

  cms_ctrl u_ctrl (
    .flagN   (flagN),
    .flagC   (flagC),
    .flagZ   (flagZ),
    .flagV   (flagV),
    .condSel (condSel),
    .opSel   (opSel),
    .strobes (strobes)
  );

  cms_datapath #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_dp (
    .strobes  (strobes),
    .sizeCode (sizeCode),
    .srcVal   (srcVal),
    .dstVal   (dstVal),
    .flagN    (flagN),
    .flagZ    (flagZ),
    .dstOut   (dstOut),
    .zOut     (zOut),
    .nOut     (nOut)
  );

  // R8: no storage anywhere on these paths
  assign dstWe  = strobes.wrDst;
  assign flagWe = strobes.wrFlags;

endmodule

// File: rtl/cms_unit_chk.sv
module cms_unit_chk #(
  parameter int DATA_W = 64,
  parameter int SIZE_W = 4
) (
  input logic              flagN,
  input logic              flagC,
  input logic              flagZ,
  input logic              flagV,
  input logic [2:0]        condSel,
  input logic [1:0]        opSel,
  input logic [SIZE_W-1:0] sizeCode,
  input logic [DATA_W-1:0] srcVal,
  input logic [DATA_W-1:0] dstVal,
  input logic [DATA_W-1:0] dstOut,
  input logic              dstWe,
  input logic              flagWe,
  input logic              zOut,
  input logic              nOut
);

  localparam int NBYTES = DATA_W / 8;

  logic anyBits;
  assign anyBits = ^{opSel, condSel, sizeCode, flagN, flagC, flagZ, flagV} !== 1'bx;

  always_comb begin
    if (anyBits) begin
      // R7: unconditional move always writes both targets
      p_move_writes_r7: assert (opSel != 2'd0 || (dstWe && flagWe))
        else $error("unconditional move without write strobes");
      // R2: idle writes nothing and passes the destination through
      p_idle_quiet_r2: assert (opSel != 2'd3 || (!dstWe && !flagWe && dstOut == dstVal))
        else $error("idle op disturbed outputs");
      // R6: set yields only 0 or 1 and never touches flags
      p_set_bit_r6: assert (opSel != 2'd2 || (dstOut[DATA_W-1:1] == '0 && dstWe && !flagWe
                                              && zOut == flagZ && nOut == flagN))
        else $error("set op result out of range");
      // R4: zero flag follows a performed move's result
      p_zero_flag_r4: assert (!flagWe || (zOut == (dstOut == '0)))
        else $error("zero flag mismatch after move");
      // R5: no flag write means flags echo inputs
      p_flag_echo_r5: assert (flagWe || (zOut == flagZ && nOut == flagN))
        else $error("flags changed without write strobe");
      // R3: a performed move never sets bytes above the clamped width
      p_upper_clear_r3: assert (!flagWe || sizeCode >= SIZE_W'(NBYTES - 1)
                                || (dstOut >> ((int'(sizeCode) + 1) * 8)) == '0)
        else $error("bytes above operand width not cleared");
    end
  end

endmodule

bind cms_unit cms_unit_chk #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_chk (.*);

// File: tb/test_cms_unit.sv
`timescale 1ns/1ps
module test_cms_unit;

  logic        clk = 1'b0;
  logic        flagN, flagC, flagZ, flagV;
  logic [2:0]  condSel;
  logic [1:0]  opSel;
  logic [3:0]  sizeCode;
  logic [63:0] srcVal, dstVal;
  logic [63:0] dstOut;
  logic        dstWe, flagWe, zOut, nOut;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  cms_unit i_cms_unit (
    .flagN(flagN), .flagC(flagC), .flagZ(flagZ), .flagV(flagV),
    .condSel(condSel), .opSel(opSel), .sizeCode(sizeCode),
    .srcVal(srcVal), .dstVal(dstVal),
    .dstOut(dstOut), .dstWe(dstWe), .flagWe(flagWe), .zOut(zOut), .nOut(nOut)
  );

  function automatic logic cond_of(input logic [3:0] f, input logic [2:0] c);
    logic pick;
    case (c[2:1])
      2'd0: pick = f[0];  // N
      2'd1: pick = f[1];  // C
      2'd2: pick = f[2];  // Z
      default: pick = f[3];  // V
    endcase
    return c[0] ? !pick : pick;
  endfunction

  task automatic check(input string tag, input logic [63:0] eOut, input logic eWe,
                       input logic eFwe, input logic eZ, input logic eN);
    total++;
    if (dstOut !== eOut || dstWe !== eWe || flagWe !== eFwe || zOut !== eZ || nOut !== eN) begin
      bad++;
      $display("FAIL %s op=%0d cond=%0d size=%0d: got out=%h we=%b fwe=%b z=%b n=%b exp out=%h we=%b fwe=%b z=%b n=%b",
               tag, opSel, condSel, sizeCode, dstOut, dstWe, flagWe, zOut, nOut,
               eOut, eWe, eFwe, eZ, eN);
    end
  endtask

  task automatic run_vec(input string forceTag, input logic [3:0] f, input logic [2:0] c,
                         input logic [1:0] o, input logic [3:0] s,
                         input logic [63:0] src, input logic [63:0] dst);
    int          sz;
    logic [63:0] mv;
    logic        nb, tk;
    string       tag;
    @(negedge clk);
    {flagV, flagZ, flagC, flagN} = f;
    condSel = c; opSel = o; sizeCode = s; srcVal = src; dstVal = dst;
    #1;  // R8: same-cycle sampling, no clock edge in between
    sz = (s > 4'd7) ? 7 : int'(s);
    mv = (sz == 7) ? src : (src & ((64'd1 << ((sz + 1) * 8)) - 64'd1));
    nb = mv[(sz + 1) * 8 - 1];
    tk = cond_of(f, c);
    case (o)
      2'd0: begin
        tag = (forceTag != "") ? forceTag : "R7";
        check(tag, mv, 1'b1, 1'b1, mv == 64'd0, nb);
      end
      2'd1: begin
        if (tk) begin
          tag = (forceTag != "") ? forceTag : "R4";
          check(tag, mv, 1'b1, 1'b1, mv == 64'd0, nb);
        end else begin
          tag = (forceTag != "") ? forceTag : "R5";
          check(tag, dst, 1'b0, 1'b0, f[2], f[0]);
        end
      end
      2'd2: begin
        tag = (forceTag != "") ? forceTag : "R6";
        check(tag, {63'd0, tk}, 1'b1, 1'b0, f[2], f[0]);
      end
      default: begin
        tag = (forceTag != "") ? forceTag : "R2";
        check(tag, dst, 1'b0, 1'b0, f[2], f[0]);
      end
    endcase
  endtask

  initial begin
    logic [63:0] pats [4];
    pats[0] = 64'h0000_0000_0000_0000;
    pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[2] = 64'h8000_7F80_0100_FF80;
    pats[3] = 64'h0123_4567_89AB_CDEF;

    // Baseline: all-zero inputs, unconditional move of zero
    run_vec("R4", 4'h0, 3'd0, 2'd0, 4'd0, 64'd0, 64'd0);

    // R1: each flag and polarity through the set op
    run_vec("R1", 4'b0001, 3'd0, 2'd2, 4'd0, 64'd0, 64'h55);  // N set -> 1
    run_vec("R1", 4'b0001, 3'd1, 2'd2, 4'd0, 64'd0, 64'h55);  // N clear -> 0
    run_vec("R1", 4'b0010, 3'd2, 2'd2, 4'd0, 64'd0, 64'h55);  // C set -> 1
    run_vec("R1", 4'b0100, 3'd5, 2'd2, 4'd0, 64'd0, 64'h55);  // Z clear -> 0
    run_vec("R1", 4'b0000, 3'd7, 2'd2, 4'd0, 64'd0, 64'h55);  // V clear -> 1

    // R3: clamped code keeps all bytes; code 0 keeps one byte
    run_vec("R3", 4'h0, 3'd0, 2'd0, 4'd12, 64'hF123_4567_89AB_CDEF, 64'd0);
    run_vec("R3", 4'h0, 3'd0, 2'd0, 4'd0,  64'h0123_4567_89AB_CD80, 64'd0);
    run_vec("R3", 4'h0, 3'd0, 2'd0, 4'd2,  64'hFFFF_FFFF_FF00_0000, 64'd0);

    // Full sweep
    for (int o = 0; o < 4; o++)
      for (int c = 0; c < 8; c++)
        for (int f = 0; f < 16; f++)
          for (int s = 0; s < 16; s++)
            for (int p = 0; p < 4; p++)
              run_vec("", 4'(f), 3'(c), 2'(o), 4'(s), pats[p],
                      64'hDEAD_BEEF_CAFE_F00D ^ {60'd0, 4'(p)});
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout exp completion");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule